// File: doc/BRIEF.md
# Four-Phase Host Register Bus Sequencer

This block sits between an external host bus and the register file of a multi-channel serial peripheral. It runs on the system clock. It watches an active-low chip select, a write/read-not line, an address and a write data bus. Every access the host starts is carried out as a fixed internal sequence of four clock phases, named C1 to C4. During that sequence the block issues read and write strobes to the internal registers, captures the read data and gives the host an active-low acknowledge.

A mode input picks how chip select is read. In single mode, one chip-select assertion gives exactly one access. In burst mode, accesses follow each other every four clocks for as long as chip select stays low. Raising chip select ends whatever is in progress.

The address is split into a region bit and a register index. Address bit 7 chooses the data region or the control region. Bits 5:0 give the index. Bit 6 plays no part in the decode.

Top module: `hostbus_seq`

## Requirements
- R1: When a rising clock edge samples `cs_n` low while the block is idle and free to start, the next clock period is C1. C2, C3 and C4 follow on the next three periods. Address, direction and write data are latched at that same edge.
- R2: `dack_n` is low for exactly one period, and that period is C4 of a completed access.
- R3: For a write (`wr_rd_n` = 1), `reg_wr` is high for exactly the C3 period. During that period `reg_wdata` carries the latched write data.
- R4: For a read (`wr_rd_n` = 0), `reg_rd` is high during C2 and C3. The value on `rdata_in` at the edge that ends C3 appears on `rdata` in C4. `rd_valid` is high during C4 only.
- R5: With `burst_mode` = 0, one assertion of `cs_n` gives exactly one access, however long `cs_n` stays low. A new access needs `cs_n` to be sampled high first.
- R6: With `burst_mode` = 1 and `cs_n` held low, the edge that ends C4 starts a new C1, relatching the inputs. This gives one acknowledge every four clocks.
- R7: Address bit 6 is ignored. `reg_idx` equals address bits 5:0.
- R8: Address bit 7 = 1 raises `data_sel` and bit 7 = 0 raises `ctrl_sel`, only while an access is in progress. The two are never high together.
- R9: `cs_n` going high part way through an access ends it at once. From then on, that access gives no write strobe, no read-valid flag and no acknowledge.
- R10: `rst_n` low clears the block immediately, whatever the clock is doing. `dack_n` is high and all strobes and selects are low. The reset must be held at least 10 clocks by the system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_mode | input | 1 | 1 = back-to-back accesses while selected, 0 = one access per select |
| cs_n | input | 1 | Active-low chip select |
| wr_rd_n | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Host address; bit 7 region, bit 6 unused, bits 5:0 index |
| wdata | input | 8 | Host write data |
| rdata_in | input | 8 | Read data from the addressed internal register |
| dack_n | output | 1 | Active-low data acknowledge, low in C4 |
| reg_wr | output | 1 | Internal write strobe, C3 |
| reg_rd | output | 1 | Internal read strobe, C2 and C3 |
| data_sel | output | 1 | Access targets the data region |
| ctrl_sel | output | 1 | Access targets the control region |
| reg_idx | output | 6 | Latched register index |
| reg_wdata | output | 8 | Latched write data |
| rdata | output | 8 | Captured read data toward the host |
| rd_valid | output | 1 | `rdata` valid, C4 of a read |

## Verification
The bench targets the following corner cases:
- Chip select held low long past C4 in single mode. A design that re-armed on its own would acknowledge two or three times.
- The same hold in burst mode. A design with an idle gap between accesses would space its acknowledges wider than four clocks.
- Chip select raised during C2 of a write and during C3 of a read. A design that only finished cycles would still pulse the write strobe or the acknowledge.
- Addresses that differ only in bit 6. A leaky decode would change the index.
- A reset that lands mid-access. A design with a synchronous reset would not clear the strobes at once.

// File: rtl/hostbus_seq.sv
module hostbus_seq #(
  parameter int DW   = 8,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            burst_mode,
  input  logic            cs_n,
  input  logic            wr_rd_n,
  input  logic [IDXW+1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   rdata_in,
  output logic            dack_n,
  output logic            reg_wr,
  output logic            reg_rd,
  output logic            data_sel,
  output logic            ctrl_sel,
  output logic [IDXW-1:0] reg_idx,
  output logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   rdata,
  output logic            rd_valid
);
  localparam int AW = IDXW + 2;
  localparam logic [1:0] C1 = 2'd0, C2 = 2'd1, C3 = 2'd2, C4 = 2'd3;

  logic          busy, hold_off, wr_q;
  logic [1:0]    ph;
  logic [IDXW:0] a_q;
  logic [DW-1:0] wd_q, rd_q;

  wire act   = busy && !cs_n;
  wire abort = busy && cs_n;
  wire go    = !cs_n && (busy ? (ph == C4 && burst_mode) : !hold_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= C1;
      wr_q <= 1'b0;
      a_q  <= '0;
      wd_q <= '0;
      rd_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      ph   <= C1;
    end else if (go) begin
      busy <= 1'b1;
      ph   <= C1;
      wr_q <= wr_rd_n;
      a_q  <= {addr[AW-1], addr[IDXW-1:0]};
      wd_q <= wdata;
    end else if (busy) begin
      if (ph == C4) busy <= 1'b0;
      else ph <= ph + 2'd1;
      if (ph == C3 && !wr_q) rd_q <= rdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_off <= 1'b0;
    else if (cs_n) hold_off <= 1'b0;
    else if (busy && ph == C4 && !burst_mode) hold_off <= 1'b1;
  end

  assign dack_n    = !(act && ph == C4);
  assign reg_wr    = act && wr_q && ph == C3;
  assign reg_rd    = act && !wr_q && (ph == C2 || ph == C3);
  assign rd_valid  = act && !wr_q && ph == C4;
  assign data_sel  = act && a_q[IDXW];
  assign ctrl_sel  = act && !a_q[IDXW];
  assign reg_idx   = a_q[IDXW-1:0];
  assign reg_wdata = wd_q;
  assign rdata     = rd_q;

  assert_ack_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dack_n |=> dack_n);
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_wr_then_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (!dack_n || cs_n));
  assert_rdv_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(reg_rd));
  assert_single_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dack_n && !burst_mode) |=> !data_sel && !ctrl_sel);
  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_sel, ctrl_sel}));
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (dack_n && !reg_wr && !rd_valid));
endmodule

// File: tb/hostbus_seq_test.sv
`timescale 1ns/1ps
module hostbus_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, burst_mode = 1'b0, cs_n = 1'b1, wr_rd_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata_in, rdata, reg_wdata;
  logic [5:0] reg_idx;
  logic dack_n, reg_wr, reg_rd, data_sel, ctrl_sel, rd_valid;
  int total = 0, bad = 0;
  int n_ack, first_ack, last_ack, n_wr, wr_at, n_rd, first_rd, n_rdv, wr_sel;
  logic [7:0] wr_seen, rd_seen;
  logic [5:0] idx_seen;

  always #5 clk = ~clk;

  assign rdata_in = {data_sel, 1'b0, reg_idx} ^ 8'hA5;

  hostbus_seq uut (.clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .cs_n(cs_n),
    .wr_rd_n(wr_rd_n), .addr(addr), .wdata(wdata), .rdata_in(rdata_in),
    .dack_n(dack_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .data_sel(data_sel),
    .ctrl_sel(ctrl_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .rdata(rdata), .rd_valid(rd_valid));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic watch(input int n, input int release_at);
    n_ack = 0; first_ack = 0; last_ack = 0; n_wr = 0; wr_at = 0;
    n_rd = 0; first_rd = 0; n_rdv = 0; wr_sel = 0;
    wr_seen = '0; rd_seen = '0; idx_seen = '0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (!dack_n) begin n_ack++; if (first_ack == 0) first_ack = i; last_ack = i; end
      if (reg_wr) begin
        n_wr++; wr_at = i; wr_seen = reg_wdata; idx_seen = reg_idx;
        wr_sel = {30'd0, data_sel, ctrl_sel};
      end
      if (reg_rd) begin n_rd++; if (first_rd == 0) first_rd = i; end
      if (rd_valid) begin n_rdv++; rd_seen = rdata; end
      if (i == release_at) cs_n = 1'b1;
    end
  endtask

  task automatic start(input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_rd_n = w; addr = a; wdata = d; cs_n = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 dack_n idle", dack_n, 1);
    chk("R10 strobes idle", {reg_wr, reg_rd, rd_valid, data_sel, ctrl_sel}, 0);
  endtask

  task automatic t_write;
    burst_mode = 1'b0;
    start(1'b1, 8'h9C, 8'h3E);
    watch(6, 4);
    chk("R1 write ack in C4", first_ack, 4);
    chk("R2 single ack", n_ack, 1);
    chk("R3 one write strobe", n_wr, 1);
    chk("R3 write strobe in C3", wr_at, 3);
    chk("R3 write data", wr_seen, 8'h3E);
    chk("R7 index", idx_seen, 6'h1C);
    chk("R8 data region", wr_sel, 2);
    chk("R4 no read strobe on write", n_rd, 0);
  endtask

  task automatic t_read;
    start(1'b0, 8'hC3, 8'h00);
    watch(6, 4);
    chk("R4 read strobe count", n_rd, 2);
    chk("R4 read strobe from C2", first_rd, 2);
    chk("R4 read valid in C4 only", n_rdv, 1);
    chk("R4 read data", rd_seen, 8'h26);
    chk("R2 read ack in C4", first_ack, 4);
    chk("R3 no write on read", n_wr, 0);
  endtask

  task automatic t_bit6;
    start(1'b1, 8'h45, 8'h11);
    watch(6, 4);
    chk("R7 bit6 set index", idx_seen, 6'h05);
    chk("R8 control region", wr_sel, 1);
    start(1'b1, 8'h05, 8'h12);
    watch(6, 4);
    chk("R7 bit6 clear index", idx_seen, 6'h05);
  endtask

  task automatic t_single_hold;
    burst_mode = 1'b0;
    start(1'b1, 8'h01, 8'h77);
    watch(14, 12);
    chk("R5 one ack per select", n_ack, 1);
    chk("R5 one write per select", n_wr, 1);
  endtask

  task automatic t_burst;
    burst_mode = 1'b1;
    start(1'b1, 8'h82, 8'h55);
    watch(14, 12);
    chk("R6 burst ack count", n_ack, 3);
    chk("R6 burst first ack", first_ack, 4);
    chk("R6 burst last ack", last_ack, 12);
    chk("R6 burst writes", n_wr, 3);
    burst_mode = 1'b0;
  endtask

  task automatic t_abort;
    start(1'b1, 8'h10, 8'hAA);
    watch(6, 2);
    chk("R9 aborted write no strobe", n_wr, 0);
    chk("R9 aborted write no ack", n_ack, 0);
    start(1'b0, 8'h10, 8'h00);
    watch(6, 3);
    chk("R9 aborted read no valid", n_rdv, 0);
    chk("R9 aborted read no ack", n_ack, 0);
    start(1'b1, 8'h11, 8'h5B);
    watch(6, 4);
    chk("R9 access after abort", wr_seen, 8'h5B);
  endtask

  task automatic t_reset_mid;
    start(1'b1, 8'h20, 8'h99);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset clears ack", dack_n, 1);
    chk("R10 async reset clears strobes", {reg_wr, data_sel, ctrl_sel}, 0);
    cs_n = 1'b1;
    repeat (11) @(negedge clk);
    rst_n = 1'b1;
    watch(6, 0);
    chk("R10 no write after reset", n_wr, 0);
    chk("R10 no ack after reset", n_ack, 0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (12) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write;
    t_read;
    t_bit6;
    t_single_hold;
    t_burst;
    t_abort;
    t_reset_mid;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule